// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a ring of transmit descriptors held in shared memory and feeds the referenced buffers to a MAC-side stream. Each descriptor is four 16-bit words: word 0 holds buffer address bits 15:0, word 1 holds address bits 23:16 in its low byte and a status byte in its high byte, word 2 holds the buffer length as a negative byte count, and word 3 holds secondary (error) status. The host hands a descriptor to the engine by setting the ownership bit. The engine clears that bit when it writes the descriptor back.

A frame may span several descriptors. A start mark and an end mark in the status byte delimit it. After the buffer with the end mark has been streamed, the engine waits for a completion report from the MAC. It then writes the secondary status, and after that the status byte. A one-cycle completion pulse follows. When a frame is chained, the engine checks that the following descriptor is owned before it releases the current one. If the following descriptor is not owned, the engine closes the current descriptor with a buffer error. Underflow, retry failure and buffer error shut the transmitter down until reset.

The engine is one state machine with ten states. `IDLE` waits for a demand strobe. `RD_STAT`, `RD_ADDR` and `RD_LEN` fetch words 1, 0 and 2. `XFER` offers the buffer. `PEEK` reads word 1 of the following descriptor. `WAIT_MAC` waits for the completion report. `WR_SEC` writes word 3. `WR_STAT` writes word 1. `HALT` is the stopped state.

The transitions are:
- `IDLE` to `RD_STAT` on a demand.
- `RD_STAT` to `RD_ADDR` when the descriptor is owned, or to `IDLE` when it is not.
- `RD_ADDR` to `RD_LEN` to `XFER`.
- `XFER` to `WAIT_MAC` on the last buffer, or to `PEEK` otherwise.
- `PEEK` to `WR_STAT` when the next descriptor is owned, or to `WR_SEC` when it is not.
- `WAIT_MAC` to `WR_SEC`.
- `WR_SEC` to `WR_STAT`.
- `WR_STAT` to `HALT` on a stopping error, to `RD_STAT` after a frame closes, or to `RD_ADDR` inside a chain.

Top module: `txr_engine`

## Requirements
- R1: After reset the transmitter is on (`tx_on`=1) and `mem_req`, `buf_valid` and `tint` are all 0.
- R2: Descriptor i starts at byte address B+8*i, where B is `ring_base` with its low 2 bits forced to zero. Word k of a descriptor sits at offset 2*k. The ring holds 2^`ring_log2` descriptors.
- R3: If word 1 of a polled descriptor has bit 15 (ownership) clear, the engine neither writes that descriptor nor offers its buffer.
- R4: A buffer is offered with address {word1[7:0], word0}. The byte count is the two's-complement negation of word 2, taken to 12 bits. The first flag is status bit 1 (start) and the last flag is status bit 0 (end). All of these are held stable while `buf_ready` is low.
- R5: In a chained frame, a descriptor without the end mark is released by writing word 1 with only status bits 1:0 kept and the address byte unchanged. This happens only after the next descriptor has been read as owned, and word 3 is left untouched.
- R6: When a frame closes, word 3 is written first. Bits 15:10 carry retry failure (bit 10), carrier loss (bit 11), late collision (bit 12), underflow (bit 14) and buffer error (bit 15). Bit 13 and bits 9:0 are written as zero. Word 1 is written next. Its status byte has ownership clear, bit 2 set for deferred, bit 3 for one retry, bit 4 for several retries, bit 6 set when any bit of word 3 is set, and bits 1:0 kept.
- R7: `tint` pulses for exactly one cycle for each closed frame. The descriptor index then advances modulo the ring size, wrapping from the last descriptor to descriptor 0.
- R8: After a frame closes, the next descriptor is polled at once. If it is not owned, the engine idles until `tx_demand`, which restarts the poll at the same index.
- R9: When the descriptor after a non-final buffer is not owned, the current descriptor is closed with the buffer error. Word 3 gets 0x8000, and word 1 gets the error summary bit set and the start/end marks kept. `tint` pulses, the transmitter turns off, and the unowned descriptor is not written.
- R10: Underflow and retry failure turn `tx_on` off after the write-back. After that there is no memory access and no buffer offer, and `tx_demand` is ignored. Carrier loss and late collision leave the transmitter on.
- R11: A memory request keeps `mem_req`, `mem_we` and `mem_addr` stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_demand | input | 1 | Poll strobe from the register block |
| ring_base | input | ADDR_W | Ring base byte address (low 2 bits ignored) |
| ring_log2 | input | 3 | log2 of descriptor count |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Halfword byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with ack |
| mem_ack | input | 1 | Access completes this cycle |
| buf_valid | output | 1 | Buffer offered to MAC |
| buf_ready | input | 1 | MAC accepts buffer |
| buf_addr | output | ADDR_W | Buffer start address |
| buf_len | output | LEN_W | Buffer byte count |
| buf_first | output | 1 | First buffer of frame |
| buf_last | output | 1 | Last buffer of frame |
| mac_done | input | 1 | Frame completion report |
| mac_deferred | input | 1 | Frame was deferred |
| mac_one_retry | input | 1 | Exactly one retry |
| mac_multi_retry | input | 1 | More than one retry |
| mac_err | input | 6 | Errors in word-3 flag order (bits 3 and 5 ignored) |
| tint | output | 1 | Frame-closed pulse |
| tx_on | output | 1 | Transmitter enabled |

## Verification
The assertions assume a memory that holds each request until it acknowledges it, and returns read data in the acknowledge cycle. They also assume that `ring_base` and `ring_log2` do not change between resets, and that `mac_done` arrives only after the last buffer of a frame. The bench memory model acknowledges every request exactly one cycle after it sees it. The ring settings are written only while reset is held. The MAC model pulses the completion report two cycles after it accepts a buffer that carries the last flag, taking the flags for each frame from a queue that the test fills in frame order.

// File: rtl/txr_pkg.sv
package txr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_STAT,
        ST_RD_ADDR,
        ST_RD_LEN,
        ST_XFER,
        ST_PEEK,
        ST_WAIT_MAC,
        ST_WR_SEC,
        ST_WR_STAT,
        ST_HALT
    } txr_state_e;

    // word offsets inside a descriptor (fixed by the memory layout)
    localparam logic [1:0] W_ADDR_LO = 2'd0;
    localparam logic [1:0] W_STAT    = 2'd1;
    localparam logic [1:0] W_LEN     = 2'd2;
    localparam logic [1:0] W_SEC     = 2'd3;

    // status byte bit positions
    localparam int B_ERR  = 6;
    localparam int B_MORE = 4;
    localparam int B_ONE  = 3;
    localparam int B_DEF  = 2;
    localparam int B_STP  = 1;
    localparam int B_ENP  = 0;

    // secondary flag positions (flag field sits in word 3 bits 15:10)
    localparam int S_BUFF = 5;
    localparam int SEC_SHIFT = 10;

    // flags the MAC may report (retry fail, carrier, late coll, underflow)
    localparam logic [5:0] MAC_ERR_MASK = 6'b010111;
    // flags that switch the transmitter off
    localparam logic [5:0] HALT_MASK    = 6'b110001;

    typedef struct packed {
        logic       deferred;
        logic       one;
        logic       more;
        logic [5:0] sec;
    } txr_result_t;

endpackage

// File: rtl/txr_ring_index.sv
module txr_ring_index #(
    parameter int ADDR_W = 24,
    parameter int IDX_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              use_next,
    input  logic [1:0]        word_sel,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [2:0]        ring_log2,
    output logic [ADDR_W-1:0] desc_addr
);

    logic [IDX_W:0]   size_oh;
    logic [IDX_W-1:0] mask;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] idx_nxt;
    logic [IDX_W-1:0] sel_idx;
    logic [ADDR_W-1:0] base_al;

    always_comb begin
        size_oh = (IDX_W+1)'(1) << ring_log2;
        mask    = size_oh[IDX_W-1:0] - IDX_W'(1);
        idx_nxt = (idx + IDX_W'(1)) & mask;
        sel_idx = use_next ? idx_nxt : idx;
        base_al = ring_base & ~ADDR_W'(3);
        desc_addr = base_al + (ADDR_W'(sel_idx) << 3) + (ADDR_W'(word_sel) << 1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       idx <= '0;
        else if (advance) idx <= idx_nxt;
    end

    // R2: every access lands on a halfword inside the ring window
    a_r2_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_addr[0] == 1'b0) && ((desc_addr - base_al) < (ADDR_W'(size_oh) << 3)));

endmodule

// File: rtl/txr_status_pack.sv
module txr_status_pack import txr_pkg::*; (
    input  logic        mark_stp,
    input  logic        mark_enp,
    input  logic        final_wb,
    input  logic        buff_err,
    input  txr_result_t res,
    output logic [7:0]  stat_out,
    output logic [5:0]  sec_out,
    output logic        stop_tx
);

    always_comb begin
        sec_out = buff_err ? 6'(1 << S_BUFF) : (res.sec & MAC_ERR_MASK);
        stat_out = '0;
        stat_out[B_STP] = mark_stp;
        stat_out[B_ENP] = mark_enp;
        if (final_wb) begin
            stat_out[B_ERR] = |sec_out;
            if (!buff_err) begin
                stat_out[B_DEF]  = res.deferred;
                stat_out[B_ONE]  = res.one;
                stat_out[B_MORE] = res.more;
            end
        end
        stop_tx = final_wb && |(sec_out & HALT_MASK);
    end

endmodule

// File: rtl/txr_engine.sv
module txr_engine import txr_pkg::*; #(
    parameter int ADDR_W = 24,
    parameter int IDX_W  = 7,
    parameter int LEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_demand,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [2:0]        ring_log2,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    input  logic              mem_ack,
    output logic              buf_valid,
    input  logic              buf_ready,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [LEN_W-1:0]  buf_len,
    output logic              buf_first,
    output logic              buf_last,
    input  logic              mac_done,
    input  logic              mac_deferred,
    input  logic              mac_one_retry,
    input  logic              mac_multi_retry,
    input  logic [5:0]        mac_err,
    output logic              tint,
    output logic              tx_on
);

    localparam int HW = 16;
    localparam int OWN_BIT = HW - 1;

    txr_state_e  state, state_nxt;
    logic [7:0]  cur_hi, nxt_hi;
    logic        cur_stp, cur_enp, nxt_stp, nxt_enp;
    logic [HW-1:0] addr_lo;
    logic [LEN_W-1:0] byte_cnt;
    logic        buff_err;
    txr_result_t res;
    logic        tint_q;

    logic        advance, use_next, final_wb, stop_tx;
    logic [1:0]  word_sel;
    logic [7:0]  stat_out;
    logic [5:0]  sec_out;

    assign final_wb = cur_enp || buff_err;

    txr_ring_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_index (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (advance),
        .use_next  (use_next),
        .word_sel  (word_sel),
        .ring_base (ring_base),
        .ring_log2 (ring_log2),
        .desc_addr (mem_addr)
    );

    txr_status_pack u_pack (
        .mark_stp (cur_stp),
        .mark_enp (cur_enp),
        .final_wb (final_wb),
        .buff_err (buff_err),
        .res      (res),
        .stat_out (stat_out),
        .sec_out  (sec_out),
        .stop_tx  (stop_tx)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:     if (tx_demand) state_nxt = ST_RD_STAT;
            ST_RD_STAT:  if (mem_ack) state_nxt = mem_rdata[OWN_BIT] ? ST_RD_ADDR : ST_IDLE;
            ST_RD_ADDR:  if (mem_ack) state_nxt = ST_RD_LEN;
            ST_RD_LEN:   if (mem_ack) state_nxt = ST_XFER;
            ST_XFER:     if (buf_ready) state_nxt = cur_enp ? ST_WAIT_MAC : ST_PEEK;
            ST_PEEK:     if (mem_ack) state_nxt = mem_rdata[OWN_BIT] ? ST_WR_STAT : ST_WR_SEC;
            ST_WAIT_MAC: if (mac_done) state_nxt = ST_WR_SEC;
            ST_WR_SEC:   if (mem_ack) state_nxt = ST_WR_STAT;
            ST_WR_STAT:  if (mem_ack) state_nxt = stop_tx ? ST_HALT :
                                                  (final_wb ? ST_RD_STAT : ST_RD_ADDR);
            ST_HALT:     state_nxt = ST_HALT;
            default:     state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        word_sel  = W_STAT;
        use_next  = 1'b0;
        buf_valid = 1'b0;
        advance   = 1'b0;
        tx_on     = 1'b1;
        unique case (state)
            ST_IDLE, ST_XFER, ST_WAIT_MAC: begin
                buf_valid = (state == ST_XFER);
            end
            ST_RD_STAT: mem_req = 1'b1;
            ST_RD_ADDR: begin
                mem_req  = 1'b1;
                word_sel = W_ADDR_LO;
            end
            ST_RD_LEN: begin
                mem_req  = 1'b1;
                word_sel = W_LEN;
            end
            ST_PEEK: begin
                mem_req  = 1'b1;
                use_next = 1'b1;
            end
            ST_WR_SEC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                word_sel  = W_SEC;
                mem_wdata = {sec_out, {SEC_SHIFT{1'b0}}};
            end
            ST_WR_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = {stat_out, cur_hi};
                advance   = mem_ack;
            end
            ST_HALT: tx_on = 1'b0;
            default: ;
        endcase
    end

    assign buf_addr  = ADDR_W'({cur_hi, addr_lo});
    assign buf_len   = byte_cnt;
    assign buf_first = cur_stp;
    assign buf_last  = cur_enp;
    assign tint      = tint_q;

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_hi   <= '0;
            cur_stp  <= 1'b0;
            cur_enp  <= 1'b0;
            nxt_hi   <= '0;
            nxt_stp  <= 1'b0;
            nxt_enp  <= 1'b0;
            addr_lo  <= '0;
            byte_cnt <= '0;
            buff_err <= 1'b0;
            res      <= '0;
            tint_q   <= 1'b0;
        end else begin
            tint_q <= (state == ST_WR_STAT) && mem_ack && final_wb;
            unique case (state)
                ST_RD_STAT: if (mem_ack && mem_rdata[OWN_BIT]) begin
                    cur_hi   <= mem_rdata[7:0];
                    cur_stp  <= mem_rdata[8+B_STP];
                    cur_enp  <= mem_rdata[8+B_ENP];
                    buff_err <= 1'b0;
                    res      <= '0;
                end
                ST_RD_ADDR: if (mem_ack) addr_lo <= mem_rdata;
                ST_RD_LEN:  if (mem_ack) byte_cnt <= LEN_W'(~mem_rdata + 16'd1);
                ST_PEEK: if (mem_ack) begin
                    nxt_hi  <= mem_rdata[7:0];
                    nxt_stp <= mem_rdata[8+B_STP];
                    nxt_enp <= mem_rdata[8+B_ENP];
                    if (!mem_rdata[OWN_BIT]) buff_err <= 1'b1;
                end
                ST_WAIT_MAC: if (mac_done) begin
                    res.deferred <= mac_deferred;
                    res.one      <= mac_one_retry;
                    res.more     <= mac_multi_retry;
                    res.sec      <= mac_err;
                end
                ST_WR_STAT: if (mem_ack && !final_wb) begin
                    cur_hi  <= nxt_hi;
                    cur_stp <= nxt_stp;
                    cur_enp <= nxt_enp;
                end
                default: ;
            endcase
        end
    end

    // R11: request held until acknowledged
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R4: offered buffer stays put while the MAC stalls
    a_r4_buf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_valid && !buf_ready) |=> (buf_valid && $stable(buf_addr) && $stable(buf_len)
                                       && $stable(buf_first) && $stable(buf_last)));

    // R6: every status write returns ownership to the host
    a_r6_own_released: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_ack && (mem_addr[2:1] == W_STAT)) |-> !mem_wdata[OWN_BIT]);

    // R7: completion pulse lasts one cycle and follows a finished write
    a_r7_tint_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tint |=> !tint);
    a_r7_tint_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tint) |-> $past(mem_we && mem_ack));

    // R10: a stopped transmitter stays stopped and quiet
    a_r10_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_on |-> (!mem_req && !buf_valid));
    a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_on |=> !tx_on);

endmodule

// File: tb/sim_txr_engine.sv
module sim_txr_engine;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_demand = 1'b0;
    logic [AW-1:0] ring_base = '0;
    logic [2:0] ring_log2 = '0;
    logic mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic mem_ack = 1'b0;
    logic buf_valid;
    logic buf_ready = 1'b0;
    logic [AW-1:0] buf_addr;
    logic [11:0] buf_len;
    logic buf_first, buf_last;
    logic mac_done = 1'b0, mac_deferred = 1'b0, mac_one_retry = 1'b0, mac_multi_retry = 1'b0;
    logic [5:0] mac_err = '0;
    logic tint, tx_on;

    int checks = 0;
    int errors = 0;
    int tint_cnt = 0;
    int stall_cfg = 0;
    int stall_left = 0;
    int mac_wait = 0;

    logic [15:0] mem [0:255];
    logic [37:0] exp_buf[$];   // {addr, len, first, last}
    logic [39:0] exp_wr[$];    // {addr, data}
    logic [8:0]  mac_q[$];     // {def, one, more, err}

    always #(CLK_PERIOD/2) clk = ~clk;

    txr_engine u0 (
        .clk(clk), .rst_n(rst_n), .tx_demand(tx_demand),
        .ring_base(ring_base), .ring_log2(ring_log2),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .buf_valid(buf_valid), .buf_ready(buf_ready), .buf_addr(buf_addr),
        .buf_len(buf_len), .buf_first(buf_first), .buf_last(buf_last),
        .mac_done(mac_done), .mac_deferred(mac_deferred),
        .mac_one_retry(mac_one_retry), .mac_multi_retry(mac_multi_retry),
        .mac_err(mac_err), .tint(tint), .tx_on(tx_on)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory model: one-cycle acknowledge
    always @(posedge clk) begin
        if (!rst_n) mem_ack <= 1'b0;
        else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[8:1]] = mem_wdata;
            else        mem_rdata <= mem[mem_addr[8:1]];
        end else mem_ack <= 1'b0;
    end

    // monitor / scoreboard, away from the active edge
    always @(negedge clk) begin
        logic [8:0] m;
        logic [37:0] eb;
        logic [39:0] ew;
        if (rst_n) begin
            if (tint) tint_cnt++;
            mac_done = 1'b0;
            if (mac_wait > 0) begin
                mac_wait--;
                if (mac_wait == 0) mac_done = 1'b1;
            end
            if (mem_ack && mem_we) begin
                if (exp_wr.size() == 0) chk(1'b0, "R5/R6 unexpected write", {mem_addr, mem_wdata}, 0);
                else begin
                    ew = exp_wr.pop_front();
                    chk({mem_addr, mem_wdata} == ew, "R6 write-back", {mem_addr, mem_wdata}, ew);
                end
            end
            if (buf_valid) begin
                if (stall_left > 0) begin
                    buf_ready = 1'b0;
                    stall_left--;
                end else begin
                    buf_ready = 1'b1;
                    stall_left = stall_cfg;
                    if (exp_buf.size() == 0) chk(1'b0, "R3/R4 unexpected buffer", {buf_addr, buf_len}, 0);
                    else begin
                        eb = exp_buf.pop_front();
                        chk({buf_addr, buf_len, buf_first, buf_last} == eb, "R4 buffer",
                            {buf_addr, buf_len, buf_first, buf_last}, eb);
                    end
                    if (buf_last) begin
                        if (mac_q.size() == 0) chk(1'b0, "R6 no mac result", 0, 1);
                        else begin
                            m = mac_q.pop_front();
                            {mac_deferred, mac_one_retry, mac_multi_retry, mac_err} = m;
                            mac_wait = 2;
                        end
                    end
                end
            end else buf_ready = 1'b0;
        end
    end

    task automatic do_reset(input logic [AW-1:0] base, input logic [2:0] lg);
        @(negedge clk);
        rst_n = 1'b0;
        ring_base = base;
        ring_log2 = lg;
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        tint_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic put_desc(input int at, input logic [23:0] a, input int nbytes, input logic [7:0] st);
        mem[(at >> 1)]     = a[15:0];
        mem[(at >> 1) + 1] = {st, a[23:16]};
        mem[(at >> 1) + 2] = 16'(0 - nbytes);
        mem[(at >> 1) + 3] = 16'hBEEF;
    endtask

    task automatic demand();
        @(negedge clk);
        tx_demand = 1'b1;
        @(negedge clk);
        tx_demand = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drained(input string req);
        chk(exp_buf.size() == 0, req, exp_buf.size(), 0);
        chk(exp_wr.size() == 0, req, exp_wr.size(), 0);
    endtask

    initial begin
        // ---------------- S1 reset state and single frame ----------------
        do_reset(24'h000043, 3'd2);   // base aligns to 0x40, four descriptors
        @(negedge clk);
        chk(tx_on == 1'b1, "R1 tx_on", tx_on, 1);
        chk(mem_req == 1'b0, "R1 mem_req", mem_req, 0);
        chk(buf_valid == 1'b0, "R1 buf_valid", buf_valid, 0);
        chk(tint == 1'b0, "R1 tint", tint, 0);
        stall_cfg = 2;
        put_desc(16'h40, 24'h123456, 64, 8'h83);
        exp_buf.push_back({24'h123456, 12'd64, 1'b1, 1'b1});
        mac_q.push_back({1'b1, 1'b0, 1'b0, 6'b000000});
        exp_wr.push_back({24'h000046, 16'h0000});
        exp_wr.push_back({24'h000042, 16'h0712});
        demand();
        run(80);
        drained("R4 R6 single frame");
        chk(tint_cnt == 1, "R7 one pulse", tint_cnt, 1);
        // R3/R8: descriptor 1 still host-owned, demand does nothing
        demand();
        run(30);
        chk(mem_req == 1'b0, "R3 idle after unowned poll", mem_req, 0);
        chk(tint_cnt == 1, "R8 no frame without ownership", tint_cnt, 1);
        // R5: chained frame over descriptors 1 and 2
        put_desc(16'h48, 24'h0A1000, 100, 8'h82);
        put_desc(16'h50, 24'h0B2000, 1, 8'h81);
        exp_buf.push_back({24'h0A1000, 12'd100, 1'b1, 1'b0});
        exp_wr.push_back({24'h00004A, 16'h020A});
        exp_buf.push_back({24'h0B2000, 12'd1, 1'b0, 1'b1});
        mac_q.push_back({1'b0, 1'b1, 1'b0, 6'b000010});
        exp_wr.push_back({24'h000056, 16'h0800});
        exp_wr.push_back({24'h000052, 16'h490B});
        demand();
        run(120);
        drained("R5 chain");
        chk(mem[(16'h4E) >> 1] == 16'hBEEF, "R5 word3 untouched", mem[(16'h4E) >> 1], 16'hBEEF);
        chk(tint_cnt == 2, "R7 chain one pulse", tint_cnt, 2);
        chk(tx_on == 1'b1, "R10 carrier loss keeps tx on", tx_on, 1);
        // R7: wrap from descriptor 3 to descriptor 0
        stall_cfg = 0;
        put_desc(16'h58, 24'h0C0002, 1500, 8'h83);
        put_desc(16'h40, 24'h0D0000, 4095, 8'h83);
        exp_buf.push_back({24'h0C0002, 12'd1500, 1'b1, 1'b1});
        mac_q.push_back({1'b0, 1'b0, 1'b1, 6'b000000});
        exp_wr.push_back({24'h00005E, 16'h0000});
        exp_wr.push_back({24'h00005A, 16'h130C});
        exp_buf.push_back({24'h0D0000, 12'd4095, 1'b1, 1'b1});
        mac_q.push_back({1'b0, 1'b0, 1'b0, 6'b000100});
        exp_wr.push_back({24'h000046, 16'h1000});
        exp_wr.push_back({24'h000042, 16'h430D});
        demand();
        run(150);
        drained("R7 wrap");
        chk(tint_cnt == 4, "R7 wrap pulses", tint_cnt, 4);
        chk(tx_on == 1'b1, "R10 late collision keeps tx on", tx_on, 1);

        // ---------------- S2 buffer error ----------------
        do_reset(24'h000080, 3'd1);
        put_desc(16'h80, 24'h200010, 60, 8'h82);
        mem[(16'h8A) >> 1] = 16'h0055;
        exp_buf.push_back({24'h200010, 12'd60, 1'b1, 1'b0});
        exp_wr.push_back({24'h000086, 16'h8000});
        exp_wr.push_back({24'h000082, 16'h4220});
        demand();
        run(80);
        drained("R9 buffer error");
        chk(tx_on == 1'b0, "R9 tx off", tx_on, 0);
        chk(tint_cnt == 1, "R9 pulse", tint_cnt, 1);
        chk(mem[(16'h8A) >> 1] == 16'h0055, "R9 unowned not written", mem[(16'h8A) >> 1], 16'h0055);
        put_desc(16'h88, 24'h210000, 10, 8'h83);
        demand();
        run(40);
        chk(tx_on == 1'b0, "R10 demand ignored when off", tx_on, 0);
        chk(mem_req == 1'b0, "R10 no access when off", mem_req, 0);

        // ---------------- S3 underflow, reserved flag dropped ----------------
        do_reset(24'h000100, 3'd3);
        put_desc(16'h100, 24'h3300AA, 8, 8'h83);
        exp_buf.push_back({24'h3300AA, 12'd8, 1'b1, 1'b1});
        mac_q.push_back({1'b0, 1'b0, 1'b0, 6'b011000});
        exp_wr.push_back({24'h000106, 16'h4000});
        exp_wr.push_back({24'h000102, 16'h4333});
        demand();
        run(80);
        drained("R6 R10 underflow");
        chk(tx_on == 1'b0, "R10 underflow stops tx", tx_on, 0);

        // ---------------- S4 retry failure, single-entry ring ----------------
        do_reset(24'h000013, 3'd0);
        put_desc(16'h10, 24'h440000, 2, 8'h83);
        exp_buf.push_back({24'h440000, 12'd2, 1'b1, 1'b1});
        mac_q.push_back({1'b1, 1'b0, 1'b0, 6'b000001});
        exp_wr.push_back({24'h000016, 16'h0400});
        exp_wr.push_back({24'h000012, 16'h4744});
        demand();
        run(80);
        drained("R2 R6 retry failure");
        chk(tx_on == 1'b0, "R10 retry failure stops tx", tx_on, 0);
        chk(tint_cnt == 1, "R7 pulse", tint_cnt, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule